// File: doc/BRIEF.md
# Translation Cache with Shared-Segment Entries and Selective Purge

This block is a small fully associative translation cache for a two-level segment/page address translation. Each lookup presents the current segment-table origin, a segment index, a page index and the active translation-format code. The block answers one cycle later with a hit flag and the real frame address. Entries are loaded through a fill port from the segment-table entry word and the frame address of the page-table entry. The victim slot is picked in round-robin order.

A segment-table entry with its shared flag set gives an entry that matches under any segment-table origin. The other entries also need the origin to match. An invalidate command names a page-table origin, a page index, a frame address and the issuer's format code. It removes only the entries whose recorded values all agree with these operands. An illegal format code is reported as an error and purges nothing. A legal command waits until the `stores_drained` input reports that no store still depends on the old translations, and only then takes effect. A flush input empties the whole cache in one cycle.

Top module: `xlat_cache`

## Requirements
- R1: A lookup with `lk_v` high makes `lk_rdy` high on the next cycle. `lk_hit` is then 1 exactly when a valid entry has equal segment index, page index and format code, and either has its shared flag set or has an equal origin. `lk_frame` then gives that entry's frame, or 0 on a miss. With `lk_v` low, `lk_rdy` and `lk_hit` are 0 on the next cycle.
- R2: The shared flag is bit 30 of `fill_ste`. An entry filled with that bit set hits under any value of `lk_sto`.
- R3: An entry filled with bit 30 of `fill_ste` clear misses when `lk_sto` differs from the origin it was filled under.
- R4: Fills go to slots 0, 1, 2 and so on, wrapping after the last slot, starting from slot 0 at reset. The ninth fill after reset therefore evicts the first entry.
- R5: A purge removes an entry only when four values all equal the command's operands: the recorded format code, the page-table origin (bits 29 down to 30-PTO_W of `fill_ste`), the page index and the frame. Any single mismatch leaves the entry in place.
- R6: A format code is legal only when bits [4:3] are 01 or 10, bit 2 is 0 and bit 0 is 0. An invalidate with an illegal code raises `inv_err` for one cycle on the next cycle, does not become pending, and purges nothing.
- R7: An accepted invalidate raises `inv_busy` on the next cycle. It stays pending while `stores_drained` is low and is applied at the first clock edge where `stores_drained` is high, which also clears `inv_busy`.
- R8: `inv_req` is ignored while `inv_busy` is high.
- R9: A lookup presented in the same cycle in which a purge is applied sees the contents from before the purge.
- R10: `flush` invalidates every entry at one edge and overrides a fill in the same cycle.
- R11: After reset no entry is valid and `lk_rdy`, `lk_hit`, `inv_busy` and `inv_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_v | input | 1 | Lookup request |
| lk_sto | input | STO_W | Current segment-table origin |
| lk_sx | input | SX_W | Segment index of lookup |
| lk_px | input | PX_W | Page index of lookup |
| lk_fmt | input | 5 | Current translation-format code |
| fill_en | input | 1 | Write a new entry |
| fill_sto | input | STO_W | Origin the entry was translated under |
| fill_sx | input | SX_W | Segment index of new entry |
| fill_px | input | PX_W | Page index of new entry |
| fill_fmt | input | 5 | Format code in force at fill |
| fill_ste | input | 32 | Segment-table entry word (shared flag, page-table origin) |
| fill_frame | input | PFA_W | Frame address from the page-table entry |
| flush | input | 1 | Invalidate all entries |
| inv_req | input | 1 | Selective invalidate request |
| inv_pto | input | PTO_W | Page-table origin operand |
| inv_px | input | PX_W | Page index operand |
| inv_frame | input | PFA_W | Frame address of the page-table entry being invalidated |
| inv_fmt | input | 5 | Issuer's current format code |
| stores_drained | input | 1 | High when no store still uses old translations |
| lk_rdy | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_frame | output | PFA_W | Real frame address on hit |
| inv_busy | output | 1 | Invalidate pending |
| inv_err | output | 1 | Illegal format code on invalidate |

## Verification
The hardest case to reach is a lookup that arrives in the very cycle a purge is applied, while a second invalidate has been refused because the first was still pending. The stimulus holds `stores_drained` low so that the first command stays pending, and sends the second command during that window. It then raises `stores_drained` and a lookup of the doomed entry on the same edge. Once the `inv_busy` pulse has ended, lookups show which of the two entries survived.

// File: rtl/xc_pkg.sv
package xc_pkg;
   localparam int FMT_W      = 5;
   localparam int SEG_W      = 32;
   localparam int COMMON_BIT = 30;

   // Legal format: page code 01/10 in [4:3], bit 2 clear, segment code bit 0 clear
   function automatic logic fmt_legal(input logic [FMT_W-1:0] f);
      return ((f[4:3] == 2'b01) || (f[4:3] == 2'b10)) && !f[2] && !f[0];
   endfunction
endpackage

// File: rtl/xc_slot.sv
module xc_slot import xc_pkg::*; #(
   parameter int STO_W = 20,
   parameter int SX_W  = 4,
   parameter int PX_W  = 8,
   parameter int PTO_W = 20,
   parameter int PFA_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             clr_all,
   input  logic [STO_W-1:0] w_sto,
   input  logic [SX_W-1:0]  w_sx,
   input  logic [PX_W-1:0]  w_px,
   input  logic [FMT_W-1:0] w_fmt,
   input  logic [PTO_W-1:0] w_pto,
   input  logic             w_com,
   input  logic [PFA_W-1:0] w_pfa,
   input  logic [STO_W-1:0] q_sto,
   input  logic [SX_W-1:0]  q_sx,
   input  logic [PX_W-1:0]  q_px,
   input  logic [FMT_W-1:0] q_fmt,
   input  logic             p_go,
   input  logic [PTO_W-1:0] p_pto,
   input  logic [PX_W-1:0]  p_px,
   input  logic [PFA_W-1:0] p_pfa,
   input  logic [FMT_W-1:0] p_fmt,
   output logic             q_hit,
   output logic [PFA_W-1:0] q_pfa
);
   logic             vld;
   logic [STO_W-1:0] e_sto;
   logic [SX_W-1:0]  e_sx;
   logic [PX_W-1:0]  e_px;
   logic [FMT_W-1:0] e_fmt;
   logic [PTO_W-1:0] e_pto;
   logic             e_com;
   logic [PFA_W-1:0] e_pfa;
   logic             p_match;

   assign p_match = (e_fmt == p_fmt) && (e_pto == p_pto) &&
                    (e_px == p_px) && (e_pfa == p_pfa);

   always_ff @(posedge clk) begin
      if (!rst_n)                vld <= 1'b0;
      else if (clr_all)          vld <= 1'b0;
      else if (wr_en)            vld <= 1'b1;
      else if (p_go && p_match)  vld <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         e_sto <= w_sto;
         e_sx  <= w_sx;
         e_px  <= w_px;
         e_fmt <= w_fmt;
         e_pto <= w_pto;
         e_com <= w_com;
         e_pfa <= w_pfa;
      end
   end

   assign q_hit = vld && (e_sx == q_sx) && (e_px == q_px) && (e_fmt == q_fmt) &&
                  (e_com || (e_sto == q_sto));
   assign q_pfa = e_pfa;
endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
   parameter int ENTRIES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               adv,
   output logic [ENTRIES-1:0] sel
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam bit POW2  = (1 << IDX_W) == ENTRIES;

   logic [IDX_W-1:0] ptr;

   generate
      if (POW2) begin : g_wrap_free
         always_ff @(posedge clk) begin
            if (!rst_n)   ptr <= '0;
            else if (adv) ptr <= ptr + 1'b1;
         end
      end else begin : g_wrap_cmp
         always_ff @(posedge clk) begin
            if (!rst_n)   ptr <= '0;
            else if (adv) ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
         end
      end
   endgenerate

   always_comb begin
      sel = '0;
      sel[ptr] = 1'b1;
   end
endmodule

// File: rtl/xc_purge.sv
module xc_purge import xc_pkg::*; #(
   parameter int PTO_W = 20,
   parameter int PX_W  = 8,
   parameter int PFA_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [PTO_W-1:0] r_pto,
   input  logic [PX_W-1:0]  r_px,
   input  logic [PFA_W-1:0] r_pfa,
   input  logic [FMT_W-1:0] r_fmt,
   input  logic             drained,
   output logic             busy,
   output logic             err,
   output logic             go,
   output logic [PTO_W-1:0] h_pto,
   output logic [PX_W-1:0]  h_px,
   output logic [PFA_W-1:0] h_pfa,
   output logic [FMT_W-1:0] h_fmt
);
   logic accept;

   assign accept = req && !busy;
   assign go     = busy && drained;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         err  <= 1'b0;
      end else begin
         err <= accept && !fmt_legal(r_fmt);
         if (go)
            busy <= 1'b0;
         else if (accept && fmt_legal(r_fmt))
            busy <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         h_pto <= r_pto;
         h_px  <= r_px;
         h_pfa <= r_pfa;
         h_fmt <= r_fmt;
      end
   end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache import xc_pkg::*; #(
   parameter int ENTRIES = 8,
   parameter int STO_W   = 20,
   parameter int SX_W    = 4,
   parameter int PX_W    = 8,
   parameter int PTO_W   = 20,
   parameter int PFA_W   = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_v,
   input  logic [STO_W-1:0] lk_sto,
   input  logic [SX_W-1:0]  lk_sx,
   input  logic [PX_W-1:0]  lk_px,
   input  logic [FMT_W-1:0] lk_fmt,
   input  logic             fill_en,
   input  logic [STO_W-1:0] fill_sto,
   input  logic [SX_W-1:0]  fill_sx,
   input  logic [PX_W-1:0]  fill_px,
   input  logic [FMT_W-1:0] fill_fmt,
   input  logic [SEG_W-1:0] fill_ste,
   input  logic [PFA_W-1:0] fill_frame,
   input  logic             flush,
   input  logic             inv_req,
   input  logic [PTO_W-1:0] inv_pto,
   input  logic [PX_W-1:0]  inv_px,
   input  logic [PFA_W-1:0] inv_frame,
   input  logic [FMT_W-1:0] inv_fmt,
   input  logic             stores_drained,
   output logic             lk_rdy,
   output logic             lk_hit,
   output logic [PFA_W-1:0] lk_frame,
   output logic             inv_busy,
   output logic             inv_err
);
   localparam int PTO_LSB = COMMON_BIT - PTO_W;

   generate
      if (ENTRIES < 2) begin : g_chk_entries
         $error("xlat_cache: ENTRIES must be at least 2");
      end
      if (PTO_W < 1 || PTO_W > COMMON_BIT) begin : g_chk_pto
         $error("xlat_cache: PTO_W must fit below the shared flag");
      end
   endgenerate

   logic [ENTRIES-1:0] victim;
   logic [ENTRIES-1:0] slot_hit;
   logic [PFA_W-1:0]   slot_pfa [ENTRIES];
   logic               p_go;
   logic [PTO_W-1:0]   p_pto;
   logic [PX_W-1:0]    p_px;
   logic [PFA_W-1:0]   p_pfa;
   logic [FMT_W-1:0]   p_fmt;
   logic               hit_any;
   logic [PFA_W-1:0]   frame_or;
   logic [PTO_W-1:0]   fill_pto;

   assign fill_pto = fill_ste[PTO_LSB +: PTO_W];

   xc_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk (clk), .rst_n (rst_n), .adv (fill_en), .sel (victim)
   );

   xc_purge #(.PTO_W(PTO_W), .PX_W(PX_W), .PFA_W(PFA_W)) u_purge (
      .clk (clk), .rst_n (rst_n), .req (inv_req),
      .r_pto (inv_pto), .r_px (inv_px), .r_pfa (inv_frame), .r_fmt (inv_fmt),
      .drained (stores_drained), .busy (inv_busy), .err (inv_err), .go (p_go),
      .h_pto (p_pto), .h_px (p_px), .h_pfa (p_pfa), .h_fmt (p_fmt)
   );

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      xc_slot #(
         .STO_W(STO_W), .SX_W(SX_W), .PX_W(PX_W), .PTO_W(PTO_W), .PFA_W(PFA_W)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (fill_en && victim[i]),
         .clr_all (flush),
         .w_sto   (fill_sto),
         .w_sx    (fill_sx),
         .w_px    (fill_px),
         .w_fmt   (fill_fmt),
         .w_pto   (fill_pto),
         .w_com   (fill_ste[COMMON_BIT]),
         .w_pfa   (fill_frame),
         .q_sto   (lk_sto),
         .q_sx    (lk_sx),
         .q_px    (lk_px),
         .q_fmt   (lk_fmt),
         .p_go    (p_go),
         .p_pto   (p_pto),
         .p_px    (p_px),
         .p_pfa   (p_pfa),
         .p_fmt   (p_fmt),
         .q_hit   (slot_hit[i]),
         .q_pfa   (slot_pfa[i])
      );
   end

   always_comb begin
      hit_any  = 1'b0;
      frame_or = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (slot_hit[i]) begin
            hit_any  = 1'b1;
            frame_or = frame_or | slot_pfa[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lk_rdy   <= 1'b0;
         lk_hit   <= 1'b0;
         lk_frame <= '0;
      end else begin
         lk_rdy   <= lk_v;
         lk_hit   <= lk_v && hit_any;
         lk_frame <= (lk_v && hit_any) ? frame_or : '0;
      end
   end
endmodule

// File: rtl/xc_chk.sv
module xc_chk import xc_pkg::*; (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_v,
   input logic             flush,
   input logic             inv_req,
   input logic [FMT_W-1:0] inv_fmt,
   input logic             stores_drained,
   input logic             lk_rdy,
   input logic             lk_hit,
   input logic             inv_busy,
   input logic             inv_err
);
   // R1
   rdy_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_v |=> lk_rdy);
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_v |=> (!lk_rdy && !lk_hit));
   // R6
   bad_fmt_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_req && !inv_busy && !fmt_legal(inv_fmt)) |=> (inv_err && !inv_busy));
   // R7
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_busy && !stores_drained) |=> inv_busy);
   // R7
   pend_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_busy && stores_drained) |=> !inv_busy);
   // R8
   err_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_err |-> ($past(inv_req) && !$past(inv_busy)));
   // R10
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush ##1 lk_v) |=> !lk_hit);
endmodule

bind xlat_cache xc_chk u_chk (.*);

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_v = 0;
   logic [19:0] lk_sto = 0;
   logic [3:0]  lk_sx = 0;
   logic [7:0]  lk_px = 0;
   logic [4:0]  lk_fmt = 0;
   logic        fill_en = 0;
   logic [19:0] fill_sto = 0;
   logic [3:0]  fill_sx = 0;
   logic [7:0]  fill_px = 0;
   logic [4:0]  fill_fmt = 0;
   logic [31:0] fill_ste = 0;
   logic [11:0] fill_frame = 0;
   logic        flush = 0;
   logic        inv_req = 0;
   logic [19:0] inv_pto = 0;
   logic [7:0]  inv_px = 0;
   logic [11:0] inv_frame = 0;
   logic [4:0]  inv_fmt = 0;
   logic        stores_drained = 1;
   logic        lk_rdy, lk_hit, inv_busy, inv_err;
   logic [11:0] lk_frame;

   int checks = 0;
   int errors = 0;

   localparam logic [4:0] FA = 5'b01000;
   localparam logic [4:0] FB = 5'b10010;

   always #10 clk = ~clk;

   xlat_cache u0 (.*);

   function automatic bit legal(input logic [4:0] f);
      int pg = f / 8;
      return (pg == 1 || pg == 2) && ((f / 4) % 2 == 0) && (f % 2 == 0);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic fill(input int s, input int x, input int p, input logic [4:0] f,
                       input bit com, input int pto, input int fr);
      fill_en = 1; fill_sto = 20'(s); fill_sx = 4'(x); fill_px = 8'(p); fill_fmt = f;
      fill_ste = {1'b0, com, 20'(pto), 10'd0}; fill_frame = 12'(fr);
      @(negedge clk);
      fill_en = 0;
   endtask

   task automatic look(input int s, input int x, input int p, input logic [4:0] f,
                       output bit h, output int fr);
      lk_v = 1; lk_sto = 20'(s); lk_sx = 4'(x); lk_px = 8'(p); lk_fmt = f;
      @(negedge clk);
      h = lk_hit; fr = int'(lk_frame);
      chk(lk_rdy == 1'b1, "R1 rdy", int'(lk_rdy), 1);
      lk_v = 0;
   endtask

   task automatic inv(input int pto, input int p, input int fr, input logic [4:0] f);
      inv_req = 1; inv_pto = 20'(pto); inv_px = 8'(p); inv_frame = 12'(fr); inv_fmt = f;
      @(negedge clk);
      inv_req = 0;
   endtask

   // entry i: sto 100+i, sx i, px 3i, fmt FA, shared when i odd, pto 200+i, frame 256+i
   task automatic expect_entry(input int i, input bit present, input string req);
      bit h; int fr;
      look(100 + i, i, 3 * i, FA, h, fr);
      chk(h == present, req, h, present);
      if (present) chk(fr == 256 + i, req, fr, 256 + i);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      bit h; int fr;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      chk(!lk_rdy && !lk_hit && !inv_busy && !inv_err, "R11 outputs", int'(lk_rdy), 0);
      look(100, 0, 0, FA, h, fr);
      chk(h == 0, "R11 empty", h, 0);

      // R1 R2 R3 sweep over eight entries
      for (int i = 0; i < 8; i++) fill(100 + i, i, 3 * i, FA, i % 2, 200 + i, 256 + i);
      for (int i = 0; i < 8; i++) begin
         expect_entry(i, 1, "R1 own origin");
         look(999, i, 3 * i, FA, h, fr);
         if (i % 2) begin
            chk(h == 1, "R2 shared other origin", h, 1);
            chk(fr == 256 + i, "R2 frame", fr, 256 + i);
         end else begin
            chk(h == 0, "R3 private other origin", h, 0);
            chk(fr == 0, "R1 miss frame", fr, 0);
         end
         look(100 + i, i, 3 * i, FB, h, fr);
         chk(h == 0, "R1 format mismatch", h, 0);
         look(100 + i, i, 3 * i + 1, FA, h, fr);
         chk(h == 0, "R1 page mismatch", h, 0);
      end

      // R4 round robin: ninth fill evicts slot 0
      fill(108, 8, 24, FA, 0, 208, 264);
      expect_entry(0, 0, "R4 evicted");
      expect_entry(8, 1, "R4 ninth");
      for (int i = 1; i < 8; i++) expect_entry(i, 1, "R4 kept");

      // R5 selective purge of entry 3, one wrong operand at a time
      for (int k = 0; k < 4; k++) begin
         inv(k == 0 ? 999 : 203, k == 1 ? 10 : 9, k == 2 ? 999 : 259, k == 3 ? FB : FA);
         @(negedge clk);
         expect_entry(3, 1, "R5 mismatch keeps");
      end
      inv(203, 9, 259, FA);
      @(negedge clk);
      expect_entry(3, 0, "R5 purged");
      expect_entry(2, 1, "R5 neighbour");
      expect_entry(4, 1, "R5 neighbour");

      // R6 all 32 format codes
      for (int f = 0; f < 32; f++) begin
         inv(0, 0, 0, 5'(f));
         chk(inv_err == !legal(5'(f)), "R6 err", int'(inv_err), int'(!legal(5'(f))));
         chk(inv_busy == legal(5'(f)), "R6 pending", int'(inv_busy), int'(legal(5'(f))));
         @(negedge clk);
      end
      // R6 illegal format purges nothing even when all else matches (fills slot 1)
      fill(300, 10, 40, 5'b00000, 0, 230, 400);
      inv(230, 40, 400, 5'b00000);
      chk(inv_err == 1, "R6 err on match", int'(inv_err), 1);
      @(negedge clk);
      look(300, 10, 40, 5'b00000, h, fr);
      chk(h == 1 && fr == 400, "R6 entry kept", fr, 400);

      // R7 pending until stores drain; R8 second request dropped
      stores_drained = 0;
      inv(205, 15, 261, FA);
      chk(inv_busy == 1, "R7 busy", int'(inv_busy), 1);
      repeat (2) @(negedge clk);
      expect_entry(5, 1, "R7 held");
      chk(inv_busy == 1, "R7 still busy", int'(inv_busy), 1);
      inv(207, 21, 263, FA);
      chk(inv_err == 0, "R8 no err", int'(inv_err), 0);
      // R9 lookup in purge cycle sees old contents
      stores_drained = 1;
      lk_v = 1; lk_sto = 20'd105; lk_sx = 4'd5; lk_px = 8'd15; lk_fmt = FA;
      @(negedge clk);
      chk(lk_hit == 1, "R9 old view", int'(lk_hit), 1);
      chk(inv_busy == 0, "R7 applied", int'(inv_busy), 0);
      lk_v = 0;
      expect_entry(5, 0, "R7 purged");
      expect_entry(7, 1, "R8 ignored request");
      chk(inv_busy == 0, "R8 not pending", int'(inv_busy), 0);

      // R10 flush beats same-cycle fill
      flush = 1;
      fill(500, 12, 50, FA, 1, 240, 600);
      flush = 0;
      look(500, 12, 50, FA, h, fr);
      chk(h == 0, "R10 fill dropped", h, 0);
      expect_entry(7, 0, "R10 flushed");
      expect_entry(8, 0, "R10 flushed");
      fill(500, 12, 50, FA, 1, 240, 600);
      look(1, 12, 50, FA, h, fr);
      chk(h == 1 && fr == 600, "R10 refill", fr, 600);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule